// File: doc/BRIEF.md
# Serial Receive Path with Line Status

This block takes an asynchronous serial line and turns it into bytes for a CPU. An oversampling deserializer looks for start bits, samples each bit at its midpoint and checks parity and the stop bit. Each finished character goes into a receive queue together with two error tags: a parity mismatch and a bad stop bit. The queue can run 16 deep or as a single holding register. The CPU reads two locations over a simple register bus. Address 0 pops the head character. Address 5 returns the line status byte, and reading it clears the error flags.

Error tags travel with their own character. The status byte shows them only while that character is at the head of the queue. Overrun is raised at once when a character finishes and there is no room for it. A low stop bit is taken as the start of the next character, so the receiver can follow a stream after a framing error. A baud-rate divider outside the block supplies a sample tick at 16 times the bit rate.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset the status byte reads 0x00 and no character is available.
- R2: A frame is a low start bit, then 5 to 8 data bits LSB first (`cfg_len` 0..3 selects 5..8), then an optional parity bit, then a stop bit. Each bit lasts 16 sample ticks. Once the stop bit has been sampled, status bit 0 (data ready) is 1. A read of address 0 returns the character with the unused upper bits at 0 and removes it from the queue.
- R3: With `queue_on` = 1, up to 16 characters are held and read back in arrival order.
- R4: With `queue_on` = 1 and 16 characters held, a 17th completed character sets status bit 1 (overrun) before any read. That character is discarded and the 16 held characters are unchanged.
- R5: With `queue_on` = 0, the block holds one character. A new character that completes before the old one is read replaces it and sets status bit 1.
- R6: When `cfg_par_en` = 1, status bit 2 (parity error) marks a character whose parity bit differs from the expected one. The expected bit is the XOR of the configured data bits when `cfg_par_even` = 1, and its inverse when `cfg_par_even` = 0. No parity error is ever reported when `cfg_par_en` = 0.
- R7: A stop bit sampled low sets status bit 3 (framing error) for that character.
- R8: Parity and framing tags belong to their own character. Status bits 2 and 3 show the tags of the character at the head only, and are 0 when the queue is empty.
- R9: Reading address 5 clears status bits 1, 2 and 3, with the tags cleared for the current head. Data ready is not changed.
- R10: After a framing error the low stop bit is taken as the next start bit and checked with one more sample one tick later. If that sample is low, the data bits that follow are received without a further start bit. If it is high, the receiver goes back to idle and no extra character appears.
- R11: A low pulse that is high again at the midpoint of the start bit (tick 7) produces no character.
- R12: Changing `queue_on` empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length: 0..3 means 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| queue_on | input | 1 | 1 = 16-deep queue, 0 = single holding register |
| rd_en | input | 1 | Register read strobe; side effects happen at the clock edge |
| rd_addr | input | 3 | Register address: 0 = receive data, 5 = line status |
| rd_data | output | 8 | Read data for the current address, combinational |

## Verification
The stop bit is sampled at its eighth tick. The character is registered one clock after that and written into the queue the clock after that, and overrun is registered on that same write edge. As a result, data ready, overrun and the tags are all in place a few clocks after the stop sample. The bench drives every stop bit for its full 16 ticks, or 8 ticks for a short stop, and only then reads, so it never samples inside that window. Read data is combinational and is captured just after a falling edge while the strobe is up. The read's side effect (pop or flag clear) lands on the next rising edge, so a following read sees the updated state.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  // One received character with its own error tags
  typedef struct packed {
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_char_t;

  // XOR of the data bits that the configured length covers (5..8)
  function automatic logic word_parity(input logic [7:0] d, input logic [1:0] len);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(len) + 5) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/uart_rx_deser.sv
`timescale 1ns/1ps
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_even,
  output logic       out_valid,
  output rx_char_t   out_char
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_RESYNC
  } st_t;

  st_t           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    shf_q, shf_d;
  logic          par_q, par_d;
  logic          vld_d;
  rx_char_t      chr_d;
  logic [2:0]    last_bit;
  logic          at_sample;

  assign last_bit  = 3'(len) + 3'd4;
  assign at_sample = (cnt_q == LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    shf_d = shf_q;
    par_d = par_q;
    vld_d = 1'b0;
    chr_d = '0;
    if (tick) begin
      unique case (st_q)
        S_IDLE: begin
          if (!rxd) begin
            st_d  = S_START;
            cnt_d = '0;
          end
        end
        S_START: begin
          if (cnt_q == MID) begin
            // start must still be low at its midpoint
            if (!rxd) begin
              st_d  = S_DATA;
              cnt_d = '0;
              bit_d = '0;
              shf_d = '0;
            end else begin
              st_d = S_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (at_sample) begin
            cnt_d        = '0;
            shf_d[bit_q] = rxd;
            if (bit_q == last_bit) st_d = par_en ? S_PAR : S_STOP;
            else                   bit_d = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_PAR: begin
          if (at_sample) begin
            cnt_d = '0;
            par_d = rxd;
            st_d  = S_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_STOP: begin
          if (at_sample) begin
            vld_d      = 1'b1;
            chr_d.data = shf_q;
            chr_d.fe   = !rxd;
            chr_d.pe   = par_en & (par_q ^ word_parity(shf_q, len) ^ !par_even);
            cnt_d      = '0;
            st_d       = rxd ? S_IDLE : S_RESYNC;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_RESYNC: begin
          // second look at the low stop bit taken as a start bit
          if (!rxd) begin
            st_d  = S_DATA;
            cnt_d = CW'(1);
            bit_d = '0;
            shf_d = '0;
          end else begin
            st_d = S_IDLE;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shf_q     <= '0;
      par_q     <= 1'b0;
      out_valid <= 1'b0;
      out_char  <= '0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      bit_q     <= bit_d;
      shf_q     <= shf_d;
      par_q     <= par_d;
      out_valid <= vld_d;
      if (vld_d) out_char <= chr_d;
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     single,
  input  logic     push,
  input  rx_char_t push_data,
  input  logic     pop,
  input  logic     clr_tags,
  output rx_char_t head,
  output logic     empty,
  output logic     full,
  output logic     overrun
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  rx_char_t        mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            do_pop, wr_norm, wr_over;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = single ? !empty : (cnt_q == CNTW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign overrun = push && full && !do_pop;
  assign wr_norm = push && (!full || do_pop);
  assign wr_over = overrun && single;
  assign head    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_norm) wr_d = bump(wr_q);
      if (do_pop)  rd_d = bump(rd_q);
      cnt_d = cnt_q + CNTW'(wr_norm) - CNTW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage: no reset; a later write to the same slot wins over tag clearing
  always_ff @(posedge clk) begin
    if (clr_tags && !empty) begin
      mem[rd_q].pe <= 1'b0;
      mem[rd_q].fe <= 1'b0;
    end
    if (wr_norm && !flush) mem[wr_q] <= push_data;
    if (wr_over && !flush) mem[rd_q] <= push_data;
  end

endmodule

// File: rtl/uart_rx_status.sv
`timescale 1ns/1ps
module uart_rx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr,
  input  logic       lsr_rd,
  input  logic       empty,
  input  logic       head_pe,
  input  logic       head_fe,
  output logic [7:0] lsr
);

  logic oe_q, oe_d;

  // a new overrun in the read cycle is kept for the next read
  always_comb begin
    oe_d = oe_q;
    if (lsr_rd) oe_d = 1'b0;
    if (ovr)    oe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assign lsr = {4'b0000, head_fe & !empty, head_pe & !empty, oe_q, !empty};

endmodule

// File: rtl/uart_rx_lsr.sv
`timescale 1ns/1ps
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int OSR      = 16,
  parameter int AW       = 3,
  parameter int RBR_ADDR = 0,
  parameter int LSR_ADDR = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_even,
  input  logic          queue_on,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  rx_char_t   rx_char, head;
  logic       rx_valid;
  logic       queue_on_q, flush;
  logic       pop, lsr_rd;
  logic       fifo_empty, fifo_full, ovr;
  logic [7:0] lsr;

  assign pop    = rd_en && (rd_addr == AW'(RBR_ADDR));
  assign lsr_rd = rd_en && (rd_addr == AW'(LSR_ADDR));
  assign flush  = (queue_on != queue_on_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) queue_on_q <= 1'b1;
    else        queue_on_q <= queue_on;
  end

  uart_rx_deser #(.OSR(OSR)) i_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .rxd       (rxd),
    .len       (cfg_len),
    .par_en    (cfg_par_en),
    .par_even  (cfg_par_even),
    .out_valid (rx_valid),
    .out_char  (rx_char)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .single    (!queue_on),
    .push      (rx_valid),
    .push_data (rx_char),
    .pop       (pop),
    .clr_tags  (lsr_rd),
    .head      (head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .overrun   (ovr)
  );

  uart_rx_status i_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovr     (ovr),
    .lsr_rd  (lsr_rd),
    .empty   (fifo_empty),
    .head_pe (head.pe),
    .head_fe (head.fe),
    .lsr     (lsr)
  );

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == AW'(RBR_ADDR))      rd_data = fifo_empty ? 8'h00 : head.data;
    else if (rd_addr == AW'(LSR_ADDR)) rd_data = lsr;
  end

endmodule

// File: rtl/uart_rx_lsr_chk.sv
`timescale 1ns/1ps
module uart_rx_lsr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       flush,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       ovr,
  input logic       lsr_rd,
  input logic [7:0] lsr
);

  p_char_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !flush) |=> !fifo_empty);

  p_full_empty_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_ovr_sets_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> lsr[1]);

  p_read_clears_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr) |=> !lsr[1]);

  p_flush_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fifo_empty);

endmodule

bind uart_rx_lsr uart_rx_lsr_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .flush      (flush),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .ovr        (ovr),
  .lsr_rd     (lsr_rd),
  .lsr        (lsr)
);

// File: tb/test_uart_rx_lsr.sv
`timescale 1ns/1ps
module test_uart_rx_lsr;

  localparam int HALF = 10; // 50 MHz

  logic       clk, rst_n, sample_tick, rxd;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_even, queue_on, rd_en;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  int         total, bad;

  uart_rx_lsr i_uart_rx_lsr (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .queue_on(queue_on), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  // sample tick on every other clock: one bit = 16 ticks = 32 clocks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_tick <= 1'b0;
    else        sample_tick <= ~sample_tick;
  end

  function automatic logic [7:0] len_mask(input logic [1:0] l);
    return 8'hFF >> (3 - int'(l));
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] l, input logic even);
    logic x;
    x = ^(d & len_mask(l));
    return even ? x : ~x;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // all tasks start and end on a falling edge
  task automatic hold(input logic b, input int ticks);
    rxd = b;
    repeat (2 * ticks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip,
                            input logic stop_val, input int stop_ticks, input bit with_start);
    if (with_start) hold(1'b0, 16);
    for (int i = 0; i < int'(cfg_len) + 5; i++) hold(d[i], 16);
    if (cfg_par_en) hold(exp_par(d, cfg_len, cfg_par_even) ^ flip, 16);
    hold(stop_val, stop_ticks);
  endtask

  task automatic frame(input logic [7:0] d, input logic flip);
    send_frame(d, flip, 1'b1, 16, 1'b1);
    hold(1'b1, 3);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en   = 1'b1;
    rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, e);
  endtask

  initial begin
    #(200000 * 2 * HALF);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] fill [16];
    logic       ftag [16];
    total = 0; bad = 0;
    rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0; rd_addr = '0;
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_even = 1'b1; queue_on = 1'b1;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    expect_reg(3'd5, 8'h00, "R1 status after reset");
    expect_reg(3'd0, 8'h00, "R1 data after reset");

    // R2, R6: random lengths, parity modes and injected parity errors
    for (int n = 0; n < 14; n++) begin
      logic flip;
      cfg_len      = 2'($urandom % 4);
      cfg_par_en   = 1'($urandom);
      cfg_par_even = 1'($urandom);
      flip         = 1'($urandom);
      d            = 8'($urandom);
      frame(d, flip);
      expect_reg(3'd5, {5'b0, cfg_par_en & flip, 1'b0, 1'b1}, "R6 status after frame");
      expect_reg(3'd0, d & len_mask(cfg_len), "R2 received data");
      expect_reg(3'd5, 8'h00, "R2 empty after read");
    end

    // R3, R4, R8: fill 16 with per-character tags, then overrun
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    for (int i = 0; i < 16; i++) begin
      fill[i] = 8'($urandom);
      ftag[i] = (i % 3 == 1);
      frame(fill[i], ftag[i]);
    end
    frame(8'hEE, 1'b0);
    expect_reg(3'd5, {5'b0, ftag[0], 1'b1, 1'b1}, "R4 overrun with full queue");
    for (int i = 0; i < 16; i++) begin
      if (i > 0) expect_reg(3'd5, {5'b0, ftag[i], 1'b0, 1'b1}, "R8 head tag");
      expect_reg(3'd0, fill[i], "R3 queue order");
    end
    expect_reg(3'd5, 8'h00, "R4 extra character dropped");

    // R9: status read clears parity tag of head, data ready stays
    frame(8'h81, 1'b1);
    expect_reg(3'd5, 8'h05, "R9 parity flag shown");
    expect_reg(3'd5, 8'h01, "R9 flag cleared by read");
    expect_reg(3'd0, 8'h81, "R9 data intact");

    // R7, R10: short low stop, line high at second sample
    cfg_par_en = 1'b0;
    send_frame(8'h5A, 1'b0, 1'b0, 8, 1'b1);
    hold(1'b1, 20);
    expect_reg(3'd5, 8'h09, "R7 framing flag");
    expect_reg(3'd0, 8'h5A, "R7 framed data");
    expect_reg(3'd5, 8'h00, "R10 no extra character");

    // R10: low stop taken as next start
    send_frame(8'h3C, 1'b0, 1'b0, 16, 1'b1);
    send_frame(8'hC3, 1'b0, 1'b1, 16, 1'b0);
    hold(1'b1, 3);
    expect_reg(3'd5, 8'h09, "R10 first character tagged");
    expect_reg(3'd0, 8'h3C, "R10 first character");
    expect_reg(3'd5, 8'h01, "R10 second character clean");
    expect_reg(3'd0, 8'hC3, "R10 resync data");

    // R11: short glitch produces nothing
    hold(1'b0, 4);
    hold(1'b1, 30);
    expect_reg(3'd5, 8'h00, "R11 glitch rejected");

    // R12: mode change empties queue
    frame(8'h11, 1'b0);
    frame(8'h22, 1'b0);
    queue_on = 1'b0;
    repeat (2) @(negedge clk);
    expect_reg(3'd5, 8'h00, "R12 flush on mode change");

    // R5: single holding register overwrite
    frame(8'hA5, 1'b0);
    frame(8'h96, 1'b0);
    expect_reg(3'd5, 8'h03, "R5 overrun in single mode");
    expect_reg(3'd0, 8'h96, "R5 newest kept");
    expect_reg(3'd5, 8'h00, "R5 empty after read");

    queue_on = 1'b1;
    repeat (2) @(negedge clk);
    frame(8'h42, 1'b0);
    expect_reg(3'd0, 8'h42, "R3 queue after mode back");

    finish_run();
  end

endmodule